// File: doc/BRIEF.md
# Reservation Station Bank with Result-Bus Wakeup

This block holds the instructions of one operation class (for example floating-point add and subtract) from the time they are issued until a functional unit takes them. Each issued instruction brings an opcode, the reorder-buffer tag that will label its result, and two source operands. Each operand is either a value that is already known or the tag of the in-flight instruction that will produce it. Tag zero is reserved and means "value present".

Every cycle the bank watches one common result bus that carries a tag and a value. Any waiting operand whose producer tag equals the broadcast tag takes the value and becomes present. A station whose two operands are both present may execute. Among the stations that may execute, the one issued earliest is offered to the functional unit over a valid/ready handshake. When the handshake completes, that station is released. The issue logic sees a full flag. It may issue only when that flag is low and the reorder buffer reports a free entry.

Top module: `rsb_bank`

## Requirements
- R1: After reset no station is occupied: `full` is 0 and `fu_valid` is 0.
- R2: An issue is taken in a cycle where `iss_valid`=1, `rob_free`=1 and `full`=0. The station stores the opcode, the destination tag and both operands. An operand tag of 0 means the value given with it is present.
- R3: When `rob_free`=0 or `full`=1, an issue attempt leaves the stations unchanged.
- R4: While a station waits, each operand with a nonzero tag equal to `cdb_tag` in a cycle with `cdb_valid`=1 takes `cdb_value`. Its tag becomes 0 from the next cycle on.
- R5: An operand issued with a tag that the bus broadcasts in the same cycle takes the bus value at issue and does not wait.
- R6: `fu_valid` is 1 exactly when at least one occupied station has both operand tags equal to 0. A station issued or woken in cycle t can be offered from cycle t+1 on.
- R7: Among the stations that may execute, the one issued earliest is offered. At most one station is dispatched per cycle. The offer can move to an older station that wakes while `fu_ready` is 0.
- R8: The offered station is released in the cycle where `fu_valid` and `fu_ready` are both 1. `full` is 1 only while every station is occupied and no dispatch completes in that cycle, so an issue may reuse the station released in the same cycle.
- R9: The dispatch payload gives the station's opcode on `fu_op` and its recorded destination tag on `fu_dst`. It gives the first operand value on `fu_a` and the second on `fu_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Opcode of the issued instruction |
| iss_dst | input | TAG_W | Reorder-buffer tag of the result |
| iss_a_tag | input | TAG_W | First operand producer tag, 0 = present |
| iss_a_val | input | DATA_W | First operand value when present |
| iss_b_tag | input | TAG_W | Second operand producer tag, 0 = present |
| iss_b_val | input | DATA_W | Second operand value when present |
| rob_free | input | 1 | Reorder buffer has a free entry |
| full | output | 1 | No station can accept an issue this cycle |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_value | input | DATA_W | Broadcast result value |
| fu_valid | output | 1 | A station is offered to the functional unit |
| fu_ready | input | 1 | Functional unit accepts the offer |
| fu_op | output | OP_W | Opcode of the offered station |
| fu_dst | output | TAG_W | Destination tag of the offered station |
| fu_a | output | DATA_W | First operand of the offered station |
| fu_b | output | DATA_W | Second operand of the offered station |

## Verification
The hardest situations to reach are the ones where several things happen in one cycle. In one, a full bank completes a dispatch and accepts an issue into the station it just released. In another, a bus broadcast meets an issuing instruction that waits on that tag. Directed steps first fill every station with instructions waiting on one tag and hold `fu_ready` low. They then wake all of them at once, so the age order decides which is offered. Finally they issue on each dispatch cycle while the bank is full. Random phases use a small pool of tags, so that bus matches, same-cycle captures and younger stations waking before older ones all happen often.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
    // index width that never collapses to zero bits
    function automatic int unsigned min1_clog2(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rsb_slot.sv
module rsb_slot #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 5,
    parameter int unsigned OP_W   = 3,
    parameter int unsigned RANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [OP_W-1:0]   alloc_op_i,
    input  logic [TAG_W-1:0]  alloc_dst_i,
    input  logic [TAG_W-1:0]  alloc_a_tag_i,
    input  logic [DATA_W-1:0] alloc_a_val_i,
    input  logic [TAG_W-1:0]  alloc_b_tag_i,
    input  logic [DATA_W-1:0] alloc_b_val_i,
    input  logic [RANK_W-1:0] alloc_rank_i,
    input  logic              release_i,
    input  logic              rem_vld_i,
    input  logic [RANK_W-1:0] rem_rank_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_value_i,
    output logic              busy_o,
    output logic              ready_o,
    output logic [RANK_W-1:0] rank_o,
    output logic [OP_W-1:0]   op_o,
    output logic [TAG_W-1:0]  dst_o,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o
);
    typedef struct packed {
        logic              busy;
        logic [RANK_W-1:0] rank;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  dst;
        logic [TAG_W-1:0]  a_tag;
        logic [DATA_W-1:0] a_val;
        logic [TAG_W-1:0]  b_tag;
        logic [DATA_W-1:0] b_val;
    } slot_t;

    slot_t st_q, st_d;

    function automatic logic hit(input logic [TAG_W-1:0] t, input logic v,
                                 input logic [TAG_W-1:0] bt);
        return v && (t != '0) && (t == bt);
    endfunction

    always_comb begin
        st_d = st_q;
        if (release_i) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            if (hit(st_q.a_tag, cdb_valid_i, cdb_tag_i)) begin
                st_d.a_tag = '0;
                st_d.a_val = cdb_value_i;
            end
            if (hit(st_q.b_tag, cdb_valid_i, cdb_tag_i)) begin
                st_d.b_tag = '0;
                st_d.b_val = cdb_value_i;
            end
            if (rem_vld_i && (st_q.rank > rem_rank_i)) begin
                st_d.rank = st_q.rank - 1'b1;
            end
        end
        if (alloc_i) begin
            st_d.busy  = 1'b1;
            st_d.rank  = alloc_rank_i;
            st_d.op    = alloc_op_i;
            st_d.dst   = alloc_dst_i;
            st_d.a_tag = alloc_a_tag_i;
            st_d.a_val = alloc_a_val_i;
            st_d.b_tag = alloc_b_tag_i;
            st_d.b_val = alloc_b_val_i;
            if (hit(alloc_a_tag_i, cdb_valid_i, cdb_tag_i)) begin
                st_d.a_tag = '0;
                st_d.a_val = cdb_value_i;
            end
            if (hit(alloc_b_tag_i, cdb_valid_i, cdb_tag_i)) begin
                st_d.b_tag = '0;
                st_d.b_val = cdb_value_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = st_q.busy;
    assign ready_o = st_q.busy && (st_q.a_tag == '0) && (st_q.b_tag == '0);
    assign rank_o  = st_q.rank;
    assign op_o    = st_q.op;
    assign dst_o   = st_q.dst;
    assign a_o     = st_q.a_val;
    assign b_o     = st_q.b_val;
endmodule

// File: rtl/rsb_pick.sv
module rsb_pick #(
    parameter int unsigned N      = 4,
    parameter int unsigned RANK_W = 2
) (
    input  logic [N-1:0]             ready_i,
    input  logic [N-1:0][RANK_W-1:0] rank_i,
    output logic [N-1:0]             sel_o,
    output logic [RANK_W-1:0]        idx_o,
    output logic                     any_o
);
    logic [RANK_W-1:0] best_rank;

    always_comb begin
        any_o     = 1'b0;
        idx_o     = '0;
        best_rank = '0;
        for (int i = 0; i < N; i++) begin
            if (ready_i[i] && (!any_o || rank_i[i] < best_rank)) begin
                any_o     = 1'b1;
                idx_o     = RANK_W'(i);
                best_rank = rank_i[i];
            end
        end
        sel_o = '0;
        if (any_o) sel_o[idx_o] = 1'b1;
    end
endmodule

// File: rtl/rsb_bank.sv
module rsb_bank #(
    parameter int unsigned NUM_RS    = 4,
    parameter int unsigned ROB_DEPTH = 16,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned OP_W      = 3,
    localparam int unsigned TAG_W    = $clog2(ROB_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    input  logic              rob_free,
    output logic              full,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              fu_valid,
    input  logic              fu_ready,
    output logic [OP_W-1:0]   fu_op,
    output logic [TAG_W-1:0]  fu_dst,
    output logic [DATA_W-1:0] fu_a,
    output logic [DATA_W-1:0] fu_b
);
    localparam int unsigned RANK_W = rsb_pkg::min1_clog2(NUM_RS);
    localparam int unsigned CNT_W  = $clog2(NUM_RS + 1);

    logic [NUM_RS-1:0]             busy, rdy, sel, free_v, alloc_v, rel_v;
    logic [NUM_RS-1:0][RANK_W-1:0] rank;
    logic [NUM_RS-1:0][OP_W-1:0]   s_op;
    logic [NUM_RS-1:0][TAG_W-1:0]  s_dst;
    logic [NUM_RS-1:0][DATA_W-1:0] s_a, s_b;
    logic [RANK_W-1:0]             sel_idx, alloc_rank;
    logic                          any_rdy, fire, take;
    logic [CNT_W-1:0]              cnt;

    rsb_pick #(.N(NUM_RS), .RANK_W(RANK_W)) u_pick (
        .ready_i(rdy), .rank_i(rank), .sel_o(sel), .idx_o(sel_idx), .any_o(any_rdy)
    );

    assign fu_valid = any_rdy;
    assign fire     = any_rdy && fu_ready;
    assign rel_v    = sel & {NUM_RS{fire}};
    assign free_v   = ~busy | rel_v;
    assign full     = ~|free_v;
    assign take     = iss_valid && rob_free && !full;

    always_comb begin
        alloc_v = '0;
        cnt     = '0;
        for (int i = NUM_RS - 1; i >= 0; i--) begin
            if (free_v[i]) alloc_v = NUM_RS'(1) << i;
        end
        if (!take) alloc_v = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            cnt = cnt + CNT_W'(busy[i]);
        end
        alloc_rank = RANK_W'(cnt - CNT_W'(fire));
    end

    for (genvar g = 0; g < NUM_RS; g++) begin : g_slot
        rsb_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .RANK_W(RANK_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .alloc_i(alloc_v[g]), .alloc_op_i(iss_op), .alloc_dst_i(iss_dst),
            .alloc_a_tag_i(iss_a_tag), .alloc_a_val_i(iss_a_val),
            .alloc_b_tag_i(iss_b_tag), .alloc_b_val_i(iss_b_val),
            .alloc_rank_i(alloc_rank),
            .release_i(rel_v[g]), .rem_vld_i(fire), .rem_rank_i(rank[sel_idx]),
            .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_value_i(cdb_value),
            .busy_o(busy[g]), .ready_o(rdy[g]), .rank_o(rank[g]),
            .op_o(s_op[g]), .dst_o(s_dst[g]), .a_o(s_a[g]), .b_o(s_b[g])
        );
    end

    assign fu_op  = s_op[sel_idx];
    assign fu_dst = s_dst[sel_idx];
    assign fu_a   = s_a[sel_idx];
    assign fu_b   = s_b[sel_idx];
endmodule

// File: rtl/rsb_bank_chk.sv
module rsb_bank_chk #(
    parameter int unsigned N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         iss_valid,
    input logic         rob_free,
    input logic         full,
    input logic         fu_valid,
    input logic         fu_ready,
    input logic [N-1:0] busy,
    input logic [N-1:0] rdy,
    input logic [N-1:0] sel
);
    a_r2_issue_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && rob_free && !full && !(fu_valid && fu_ready))
        |=> ($countones(busy) == $past($countones(busy)) + 1));

    a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!(iss_valid && rob_free && !full) && !(fu_valid && fu_ready))
        |=> ($countones(busy) == $past($countones(busy))));

    a_r8_fire_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_valid && fu_ready && !(iss_valid && rob_free))
        |=> ($countones(busy) + 1 == $past($countones(busy))));

    a_r8_full_all_busy: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (&busy));

    a_r6_offer_ready: assert property (@(posedge clk) disable iff (!rst_n)
        fu_valid |-> ((sel & rdy) != '0));

    a_r7_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

bind rsb_bank rsb_bank_chk #(.N(NUM_RS)) u_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .rob_free(rob_free),
    .full(full), .fu_valid(fu_valid), .fu_ready(fu_ready),
    .busy(busy), .rdy(rdy), .sel(sel)
);

// File: tb/tb_rsb_bank.sv
module tb_rsb_bank;
    localparam int N   = 4;
    localparam int DW  = 32;
    localparam int TW  = 5;
    localparam int OPW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 0, rob_free = 0, cdb_valid = 0, fu_ready = 0;
    logic [OPW-1:0] iss_op = '0;
    logic [TW-1:0]  iss_dst = '0, iss_a_tag = '0, iss_b_tag = '0, cdb_tag = '0;
    logic [DW-1:0]  iss_a_val = '0, iss_b_val = '0, cdb_value = '0;
    logic full, fu_valid;
    logic [OPW-1:0] fu_op;
    logic [TW-1:0]  fu_dst;
    logic [DW-1:0]  fu_a, fu_b;

    always #2.5 clk = ~clk;

    rsb_bank #(.NUM_RS(N), .ROB_DEPTH(16), .DATA_W(DW), .OP_W(OPW)) dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
        .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val), .rob_free(rob_free),
        .full(full), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .fu_valid(fu_valid), .fu_ready(fu_ready), .fu_op(fu_op), .fu_dst(fu_dst),
        .fu_a(fu_a), .fu_b(fu_b)
    );

    int n_vec = 0, n_bad = 0, n_cyc = 0;
    bit done = 0;

    // age-ordered reference entries
    logic [OPW-1:0] m_op [8];
    logic [TW-1:0]  m_dst[8], m_at[8], m_bt[8];
    logic [DW-1:0]  m_av [8], m_bv[8];
    int m_n = 0;

    function automatic int oldest_ready();
        for (int i = 0; i < m_n; i++)
            if (m_at[i] == 0 && m_bt[i] == 0) return i;
        return -1;
    endfunction

    task automatic step(input string req, input logic iv, input logic [OPW-1:0] op,
                        input logic [TW-1:0] dst, input logic [TW-1:0] at, input logic [DW-1:0] av,
                        input logic [TW-1:0] bt, input logic [DW-1:0] bv, input logic rf,
                        input logic cv, input logic [TW-1:0] ct, input logic [DW-1:0] cval,
                        input logic fr);
        int e;
        logic x_full, x_fire, x_take;
        @(negedge clk);
        iss_valid = iv; iss_op = op; iss_dst = dst; iss_a_tag = at; iss_a_val = av;
        iss_b_tag = bt; iss_b_val = bv; rob_free = rf;
        cdb_valid = cv; cdb_tag = ct; cdb_value = cval; fu_ready = fr;
        #1;
        e = oldest_ready();
        x_fire = (e >= 0) && fr;
        x_full = (m_n == N) && !x_fire;
        x_take = iv && rf && !x_full;
        n_vec++;
        if (full !== x_full) begin
            n_bad++;
            $display("FAIL %s/R8 full: got %b expected %b", req, full, x_full);
        end else if (fu_valid !== (e >= 0)) begin
            n_bad++;
            $display("FAIL %s/R6 fu_valid: got %b expected %b", req, fu_valid, e >= 0);
        end else if (e >= 0 && {fu_op, fu_dst, fu_a, fu_b} !== {m_op[e], m_dst[e], m_av[e], m_bv[e]}) begin
            n_bad++;
            $display("FAIL %s/R7/R9 payload: got %h/%h/%h/%h expected %h/%h/%h/%h", req,
                     fu_op, fu_dst, fu_a, fu_b, m_op[e], m_dst[e], m_av[e], m_bv[e]);
        end
        @(posedge clk);
        // R4: broadcast wakes waiting operands
        for (int i = 0; i < m_n; i++) begin
            if (cv && ct != 0 && m_at[i] == ct) begin m_at[i] = 0; m_av[i] = cval; end
            if (cv && ct != 0 && m_bt[i] == ct) begin m_bt[i] = 0; m_bv[i] = cval; end
        end
        if (x_fire) begin
            for (int i = e; i < m_n - 1; i++) begin
                m_op[i] = m_op[i+1]; m_dst[i] = m_dst[i+1];
                m_at[i] = m_at[i+1]; m_av[i] = m_av[i+1];
                m_bt[i] = m_bt[i+1]; m_bv[i] = m_bv[i+1];
            end
            m_n--;
        end
        if (x_take) begin
            m_op[m_n] = op; m_dst[m_n] = dst;
            m_at[m_n] = at; m_av[m_n] = av; m_bt[m_n] = bt; m_bv[m_n] = bv;
            // R5: capture at issue
            if (cv && ct != 0 && at == ct) begin m_at[m_n] = 0; m_av[m_n] = cval; end
            if (cv && ct != 0 && bt == ct) begin m_bt[m_n] = 0; m_bv[m_n] = cval; end
            m_n++;
        end
    endtask

    task automatic idle(input string req, input logic fr);
        step(req, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, fr);
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 100000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired: got %0d cycles expected under 100000", n_cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: empty after reset
        idle("R1", 1);
        idle("R1", 0);
        // R5: same-cycle capture at issue
        step("R5", 1, 3'd1, 5'd9, 5'd3, 32'h0, 5'd0, 32'h5, 1, 1, 5'd3, 32'hAA, 0);
        idle("R5", 1);
        // R3: issue blocked by reorder buffer
        step("R3", 1, 3'd2, 5'd10, 5'd0, 32'h11, 5'd0, 32'h22, 0, 0, 0, 0, 0);
        idle("R3", 1);
        // R2: fill every station waiting on tag 6
        for (int i = 0; i < N; i++)
            step("R2", 1, 3'(i), 5'(12 + i), 5'd6, 32'h0, 5'd0, 32'(i), 1, 0, 0, 0, 0);
        // R3: fifth issue refused while full
        step("R3", 1, 3'd7, 5'd20, 5'd0, 32'h1, 5'd0, 32'h2, 1, 0, 0, 0, 0);
        // R4: wake all at once
        step("R4", 0, 0, 0, 0, 0, 0, 0, 1, 1, 5'd6, 32'hBEEF, 0);
        // R8: dispatch and reuse while full, R7 order, R9 payload
        for (int i = 0; i < N; i++)
            step("R8", 1, 3'd5, 5'(21 + i), 5'd0, 32'(100 + i), 5'd0, 32'h7, 1, 0, 0, 0, 1);
        for (int i = 0; i < 2 * N; i++) idle("R7", 1);
        // R7: younger ready first, then older wakes while fu_ready low
        step("R7", 1, 3'd1, 5'd2, 5'd4, 32'h0, 5'd0, 32'h1, 1, 0, 0, 0, 0);
        step("R7", 1, 3'd2, 5'd3, 5'd0, 32'h8, 5'd0, 32'h9, 1, 0, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 1, 5'd4, 32'h44, 0);
        idle("R7", 0);
        idle("R7", 1);
        idle("R9", 1);
        // random mix
        for (int k = 0; k < 4000; k++) begin
            logic [TW-1:0] at, bt;
            at = ($urandom_range(0, 1) == 0) ? 5'd0 : 5'($urandom_range(1, 5));
            bt = ($urandom_range(0, 1) == 0) ? 5'd0 : 5'($urandom_range(1, 5));
            step("R4/R7", $urandom_range(0, 9) < 6, 3'($urandom), 5'($urandom_range(1, 31)),
                 at, $urandom, bt, $urandom, $urandom_range(0, 9) < 8,
                 $urandom_range(0, 9) < 4, 5'($urandom_range(1, 5)), $urandom,
                 $urandom_range(0, 1) == 1);
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule